// File: doc/BRIEF.md
# Byte-at-a-time DBPSK modulator with register interface

This block lets a processor run a small transmit modulator one byte per command. Software stores a byte in a data register and then writes a go bit to a control register. The block splits the byte into eight one-bit symbols and sends them through a chain of three stages:

- a differential binary phase modulator,
- a four-times zero-insertion upsampler,
- a multiplier-free pulse-shaping filter.

It stores all 32 filter outputs of that byte in a bank of readable sample registers. It then raises a done flag, which software polls before it reads the samples back.

The bus side is a plain request/write/address slave with a one-cycle registered response. The modulator phase and the filter delay line are kept from one byte to the next, so that successive bytes form one continuous waveform. A clear bit in the control register aborts a run and restarts the waveform from a known state.

Top module: `byte_mod_mmio`

## Requirements
- R1: After reset the control register reads 0 (busy bit 0 clear, done bit 1 clear) and the data register reads 0.
- R2: Every bus request gets `bus_ready` high in the following cycle. A write to word offset 1 stores `bus_wdata[7:0]`, and a read of offset 1 returns that byte zero-extended. Reads of offsets 2 to 31 return 0.
- R3: A write to offset 0 with bit 0 = 1 and bit 1 = 0 while idle is accepted at that clock edge. Busy then reads 1 for exactly 34 cycles after the accepting edge. After that, busy reads 0 and done reads 1.
- R4: Symbols leave the byte MSB first. A 1 symbol flips the carrier phase and a 0 symbol keeps it. Each symbol gives the chip +1 (phase 0) or -1 (phase 1), followed by three zero chips.
- R5: The filter output for chip n is the sum over k = 0..12 of c(k)·x[n-k], with c(k) = 64 − 16·|k − 6|.
- R6: The 32 outputs of a run are readable at offsets 32..63, with output i at offset 32+i, as 16-bit signed values sign-extended to 32 bits.
- R7: A go write while busy is ignored, so the run and its timing are unchanged. A data write during a run does not change the byte being processed.
- R8: The carrier phase and the filter delay line carry over between runs. Chips from earlier runs enter later outputs.
- R9: Writing offset 0 with bit 1 = 1 clears busy, done, the phase and the delay line, and aborts any run. The sample registers keep their contents. If bit 0 is also set in the same write, no run starts.
- R10: An accepted go write clears done from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (100 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_req | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Response strobe, one cycle after the request |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |

## Verification
On every cycle, assertions check the following:
- every request is answered in the next cycle;
- busy and done are never high together;
- a filter output never arrives outside a run;
- done only rises at the end of a run;
- the symbol offered to the modulator is held while the modulator stalls.

Only the bench scenarios can show the sample values themselves. They compare the outputs against a reference waveform for several bytes in a row, which covers the phase and delay-line carry-over. The same scenarios cover the exact 34-cycle busy window, a go or data write during a run having no effect, and an abort or clear restarting the waveform while the stored samples survive.

// File: rtl/bmw_pkg.sv
package bmw_pkg;
  typedef logic signed [1:0] chip_t;

  // symmetric triangular pulse: peak at the centre tap, falling by peak/4 per tap
  function automatic int tap_coef(input int k, input int taps, input int peak);
    int d;
    d = k - (taps - 1) / 2;
    if (d < 0) d = -d;
    return peak - (peak / 4) * d;
  endfunction
endpackage

// File: rtl/bmw_bit_shifter.sv
module bmw_bit_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic [BITS-1:0] load_byte,
  input  logic            out_ready,
  output logic            out_valid,
  output logic            out_bit
);
  localparam int LEFT_W = $clog2(BITS + 1);

  logic [BITS-1:0]   sh_q, sh_n;
  logic [LEFT_W-1:0] left_q, left_n;

  assign out_valid = (left_q != '0);
  assign out_bit   = sh_q[BITS-1];

  always_comb begin
    sh_n   = sh_q;
    left_n = left_q;
    if (clr) begin
      left_n = '0;
    end else if (load) begin
      sh_n   = load_byte;
      left_n = LEFT_W'(BITS);
    end else if (out_valid && out_ready) begin
      sh_n   = sh_q << 1;
      left_n = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      sh_q   <= sh_n;
      left_q <= left_n;
    end
  end
endmodule

// File: rtl/bmw_dbpsk_up.sv
module bmw_dbpsk_up
  import bmw_pkg::*;
#(
  parameter int UP = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  in_valid,
  input  logic  in_bit,
  output logic  in_ready,
  output logic  out_valid,
  output chip_t out_chip
);
  localparam int CNT_W = (UP > 1) ? $clog2(UP) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             phase_q, phase_n;
  logic             ov_q, ov_n;
  chip_t            ox_q, ox_n;

  assign in_ready  = (cnt_q == '0);
  assign out_valid = ov_q;
  assign out_chip  = ox_q;

  always_comb begin
    cnt_n   = cnt_q;
    phase_n = phase_q;
    ov_n    = 1'b0;
    ox_n    = 2'sb00;
    if (clr) begin
      cnt_n   = '0;
      phase_n = 1'b0;
    end else if (in_valid && in_ready) begin
      phase_n = phase_q ^ in_bit;
      ox_n    = phase_n ? 2'sb11 : 2'sb01;
      ov_n    = 1'b1;
      cnt_n   = (UP > 1) ? CNT_W'(1) : '0;
    end else if (cnt_q != '0) begin
      ov_n  = 1'b1;
      cnt_n = (cnt_q == CNT_W'(UP - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      ov_q    <= 1'b0;
      ox_q    <= 2'sb00;
    end else begin
      cnt_q   <= cnt_n;
      phase_q <= phase_n;
      ov_q    <= ov_n;
      ox_q    <= ox_n;
    end
  end

  // R4: a stalled symbol stays offered and unchanged until taken
  assert_symbol_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !clr) |=> (in_valid && $stable(in_bit)));
endmodule

// File: rtl/bmw_shaper.sv
module bmw_shaper
  import bmw_pkg::*;
#(
  parameter int TAPS   = 13,
  parameter int PEAK   = 64,
  parameter int SAMP_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     in_valid,
  input  chip_t                    in_chip,
  output logic                     out_valid,
  output logic signed [SAMP_W-1:0] out_samp
);
  chip_t                    dline_q [TAPS-1];
  chip_t                    win     [TAPS];
  logic signed [SAMP_W-1:0] term    [TAPS];
  logic signed [SAMP_W-1:0] acc;
  logic                     ov_q;
  logic signed [SAMP_W-1:0] y_q;

  assign win[0] = in_chip;

  genvar k;
  generate
    for (k = 1; k < TAPS; k++) begin : g_win
      assign win[k] = dline_q[k-1];
    end
    for (k = 0; k < TAPS; k++) begin : g_tap
      localparam logic signed [SAMP_W-1:0] CF = SAMP_W'(tap_coef(k, TAPS, PEAK));
      always_comb begin
        case (win[k])
          2'sb01:  term[k] = CF;
          2'sb11:  term[k] = -CF;
          default: term[k] = '0;
        endcase
      end
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int i = 0; i < TAPS; i++) acc = acc + term[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS - 1; i++) dline_q[i] <= 2'sb00;
      ov_q <= 1'b0;
      y_q  <= '0;
    end else if (clr) begin
      for (int i = 0; i < TAPS - 1; i++) dline_q[i] <= 2'sb00;
      ov_q <= 1'b0;
    end else begin
      ov_q <= in_valid;
      if (in_valid) begin
        y_q <= acc;
        for (int i = 0; i < TAPS - 1; i++) dline_q[i] <= win[i];
      end
    end
  end

  assign out_valid = ov_q;
  assign out_samp  = y_q;
endmodule

// File: rtl/byte_mod_mmio.sv
module byte_mod_mmio
  import bmw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int BITS   = 8,
  parameter int UP     = 4,
  parameter int TAPS   = 13,
  parameter int PEAK   = 64,
  parameter int SAMP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int NS       = BITS * UP;
  localparam int IDX_W    = $clog2(NS);
  localparam int OFS_CTRL = 0;
  localparam int OFS_DATA = 1;
  localparam int OFS_SAMP = NS;

  // reset: asynchronous assert, synchronous release
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic [BITS-1:0]          data_q;
  logic                     busy_q, busy_n, done_q, done_n;
  logic [IDX_W-1:0]         idx_q, idx_n;
  logic signed [SAMP_W-1:0] samp_q [NS];
  logic                     ready_q;
  logic [DATA_W-1:0]        rdata_q, rdata_n;

  logic wr, wr_ctrl, wr_data, go, clr, cap, last;
  logic sym_v, sym_b, sym_rdy, chip_v, y_v;
  chip_t chip;
  logic signed [SAMP_W-1:0] y;
  logic unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:BITS];

  assign wr      = bus_req && bus_we;
  assign wr_ctrl = wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_data = wr && (bus_addr == ADDR_W'(OFS_DATA));
  assign clr     = wr_ctrl && bus_wdata[1];
  assign go      = wr_ctrl && bus_wdata[0] && !bus_wdata[1] && !busy_q;
  assign cap     = y_v;
  assign last    = (idx_q == IDX_W'(NS - 1));

  bmw_bit_shifter #(.BITS(BITS)) u_shift (
    .clk(clk), .rst_n(rs_n), .clr(clr), .load(go), .load_byte(data_q),
    .out_ready(sym_rdy), .out_valid(sym_v), .out_bit(sym_b)
  );

  bmw_dbpsk_up #(.UP(UP)) u_mod (
    .clk(clk), .rst_n(rs_n), .clr(clr), .in_valid(sym_v), .in_bit(sym_b),
    .in_ready(sym_rdy), .out_valid(chip_v), .out_chip(chip)
  );

  bmw_shaper #(.TAPS(TAPS), .PEAK(PEAK), .SAMP_W(SAMP_W)) u_fir (
    .clk(clk), .rst_n(rs_n), .clr(clr), .in_valid(chip_v), .in_chip(chip),
    .out_valid(y_v), .out_samp(y)
  );

  // run control next state
  always_comb begin
    busy_n = busy_q;
    done_n = done_q;
    idx_n  = idx_q;
    if (clr) begin
      busy_n = 1'b0;
      done_n = 1'b0;
      idx_n  = '0;
    end else if (go) begin
      busy_n = 1'b1;
      done_n = 1'b0;
      idx_n  = '0;
    end else if (cap) begin
      idx_n = idx_q + 1'b1;
      if (last) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  // read mux
  always_comb begin
    rdata_n = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      rdata_n[1:0] = {done_q, busy_q};
    end else if (bus_addr == ADDR_W'(OFS_DATA)) begin
      rdata_n[BITS-1:0] = data_q;
    end else if (bus_addr >= ADDR_W'(OFS_SAMP)) begin
      rdata_n = DATA_W'(samp_q[IDX_W'(bus_addr - ADDR_W'(OFS_SAMP))]);
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      busy_q  <= busy_n;
      done_q  <= done_n;
      idx_q   <= idx_n;
      ready_q <= bus_req;
      if (wr_data) data_q <= bus_wdata[BITS-1:0];
      if (bus_req && !bus_we) rdata_q <= rdata_n;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      for (int i = 0; i < NS; i++) samp_q[i] <= '0;
    end else if (cap && !clr) begin
      samp_q[idx_q] <= y;
    end
  end

  assign bus_ready = ready_q;
  assign bus_rdata = rdata_q;

  // R2: each request answered in the next cycle
  assert_req_answered_R2: assert property (@(posedge clk) disable iff (!rs_n)
    bus_req |=> bus_ready);
  // R3: never busy and done together
  assert_busy_done_excl_R3: assert property (@(posedge clk) disable iff (!rs_n)
    !(busy_q && done_q));
  // R6: filter outputs only arrive inside a run
  assert_capture_in_run_R6: assert property (@(posedge clk) disable iff (!rs_n)
    y_v |-> busy_q);
  // R3: done rises only at the end of a run
  assert_done_after_run_R3: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(done_q) |-> $past(busy_q));
endmodule

// File: tb/test_byte_mod_mmio.sv
module test_byte_mod_mmio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int ph = 0;
  int hist[$];
  int expv[32];
  int nexp;

  byte_mod_mmio i_byte_mod_mmio (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one bus transfer; called at a negedge, returns at the next negedge
  task automatic xfer(input bit we, input int a, input logic [31:0] wd, output logic [31:0] rd);
    bus_req = 1'b1; bus_we = we; bus_addr = 6'(a); bus_wdata = wd;
    @(negedge clk);
    chk(bus_ready === 1'b1, "R2 ready", bus_ready, 1);
    rd = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  function automatic int cf(input int k);
    int d = k - 6;
    if (d < 0) d = -d;
    return 64 - 16 * d;
  endfunction

  function automatic void push_chip(input int x);
    int y = 0;
    int n;
    hist.push_back(x);
    n = hist.size() - 1;
    for (int k = 0; k < 13; k++) if (n - k >= 0) y += cf(k) * hist[n - k];
    expv[nexp] = y;
    nexp++;
  endfunction

  function automatic void model_byte(input logic [7:0] b);
    nexp = 0;
    for (int i = 7; i >= 0; i--) begin
      if (b[i]) ph ^= 1;
      push_chip(ph ? -1 : 1);
      for (int j = 0; j < 3; j++) push_chip(0);
    end
  endfunction

  function automatic void model_clear();
    hist.delete();
    ph = 0;
  endfunction

  task automatic run_byte(input logic [7:0] b, input bit disturb);
    logic [31:0] rd;
    int s, e;
    bit seen_done = 0;
    xfer(1, 1, {24'd0, b}, rd);
    xfer(1, 0, 32'd1, rd);
    s = cyc;
    model_byte(b);
    for (int i = 0; i < 80 && !seen_done; i++) begin
      if (disturb && i == 4) begin
        xfer(1, 0, 32'd1, rd);            // R7 go while busy
        xfer(1, 1, {24'd0, ~b}, rd);       // R7 data during run
      end
      xfer(0, 0, 32'd0, rd);
      e = cyc - 1 - s;
      chk(rd[0] == (e >= 0 && e < 34), "R3 busy", rd[0], (e >= 0 && e < 34));
      chk(rd[1] == (e >= 34), "R3 R10 done", rd[1], (e >= 34));
      seen_done = rd[1];
    end
    for (int i = 0; i < 32; i++) begin
      xfer(0, 32 + i, 32'd0, rd);
      chk(rd == 32'(expv[i]), "R4 R5 R6 R8 sample", $signed(rd), expv[i]);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int keep5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    xfer(0, 0, 0, rd); chk(rd == 0, "R1 ctrl", rd, 0);
    xfer(0, 1, 0, rd); chk(rd == 0, "R1 data", rd, 0);
    xfer(0, 2, 0, rd); chk(rd == 0, "R2 unmapped", rd, 0);
    xfer(1, 1, 32'hFFFF_FFA5, rd);
    xfer(0, 1, 0, rd); chk(rd == 32'hA5, "R2 data readback", rd, 32'hA5);

    run_byte(8'hA5, 0);
    run_byte(8'h00, 0);          // R8 continuity
    run_byte(8'hFF, 1);          // R7 disturbances
    keep5 = expv[5];

    // R9 clear while idle: done cleared, samples retained
    xfer(1, 0, 32'd2, rd); model_clear();
    xfer(0, 0, 0, rd); chk(rd == 0, "R9 clear status", rd, 0);
    xfer(0, 37, 0, rd); chk(rd == 32'(keep5), "R9 sample kept", $signed(rd), keep5);
    run_byte(8'h3C, 0);

    // R9 abort mid-run
    xfer(1, 1, 32'h81, rd);
    xfer(1, 0, 32'd1, rd);
    repeat (5) xfer(0, 0, 0, rd);
    chk(rd[0] == 1'b1, "R9 busy before abort", rd[0], 1);
    xfer(1, 0, 32'd2, rd); model_clear();
    xfer(0, 0, 0, rd); chk(rd == 0, "R9 abort status", rd, 0);
    repeat (3) xfer(0, 0, 0, rd);
    chk(rd == 0, "R9 stays idle", rd, 0);
    run_byte(8'h81, 0);

    // R9 clear wins over go in the same write
    xfer(1, 1, 32'h5A, rd);
    xfer(1, 0, 32'd3, rd); model_clear();
    xfer(0, 0, 0, rd); chk(rd == 0, "R9 clear+go no run", rd, 0);
    run_byte(8'h5A, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule